// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the control and data path of a small synchronous pipelined burst memory. It holds 16 words of 64 bits. Each clock edge it decodes three chip enables of mixed polarity, two address strobes, an advance input and the write controls into one of five cycle types:

- deselect
- begin-read
- begin-at-external-address
- continue
- suspend

A four-beat counter produces the burst addresses. The burst order is either linear or interleaved.

Reads are pipelined. The word at the registered address passes through an array register and then an output register. The output-enable pin gates a tri-state enable. Writes are byte-granular. The byte enables and the global-write control are sampled with the write data, one edge after the address, and are not sampled with the address itself.

A three-state machine holds the data-phase type for the address that is currently registered:

- `ST_DESEL` (no access)
- `ST_RD` (read)
- `ST_WR` (write)

The transitions are:

- Any edge that decodes a deselect goes to `ST_DESEL`.
- A begin-read goes to `ST_RD`.
- A begin with a write indication goes to `ST_WR`.
- A continue or suspend from `ST_DESEL` stays in `ST_DESEL`.
- A continue or suspend from `ST_RD` or `ST_WR` goes to `ST_WR` when a write is indicated in that cycle, and to `ST_RD` otherwise.

Top module: `psram_burst_ctrl`

## Requirements
- R1: The block is selected only when ce1_n=0, ce2=1 and ce3_n=0. With ce1_n=0, a low adsp_n or adsc_n while not selected is a deselect, and no read data is driven for that cycle.
- R2: With ce1_n=1, a low adsc_n is a deselect. adsp_n is ignored whenever ce1_n=1.
- R3: With adsp_n=0 while selected, a read begins at addr_i even when gw_n, bwe_n or bw_n are asserted.
- R4: With adsp_n=1 (or ce1_n=1), adsc_n=0 and the block selected, a burst begins at addr_i. It is a write if gw_n=0 or bwe_n=0, and a read otherwise.
- R5: With both strobes inactive and adv_n=0, the burst advances by one beat, also when ce1_n=1. Beat n of a burst starting at address s keeps s[3:2] and sets bits [1:0] as follows:
  - linear_i=1: (s[1:0]+n) mod 4
  - linear_i=0: s[1:0] xor n
- R6: With both strobes inactive and adv_n=1, the address is held. A continue or suspend while deselected leaves the block deselected.
- R7: A read of the address registered at edge A puts that word on dq_o after edge A+2.
- R8: dq_oe_o is high only when oe_n=0 and the output register holds read data.
- R9: Write data and byte controls are sampled at the edge after the address edge of that beat. gw_n=0 at that edge writes all eight bytes, whatever bwe_n and bw_n are.
- R10: With gw_n=1 and bwe_n=0, byte i (bits 8i+7:8i) is written only where bw_n[i]=0. With gw_n=1 and bwe_n=1, no byte is written.
- R11: After reset the block is deselected, dq_oe_o is low and the burst count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | External word address |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Strobe that starts a read burst, active low |
| adsc_n | input | 1 | Strobe that starts a read or write burst, active low |
| adv_n | input | 1 | Burst advance, active low |
| linear_i | input | 1 | 1 selects linear burst order, 0 selects interleaved order |
| gw_n | input | 1 | Global write of all bytes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 8 | Per-byte write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| wdata_i | input | 64 | Write data |
| dq_o | output | 64 | Read data from the output register |
| dq_oe_o | output | 1 | Tri-state drive enable for dq_o |

## Verification
Every chip-enable combination is paired with each strobe, so that decode errors in selection, strobe priority and the treatment of adsp_n under a high ce1_n can be told apart. Read bursts are run from all sixteen start addresses in both burst orders, which separates add-ordering from xor-ordering and shows whether the upper address bits are kept. Further bursts mix in suspends, continues with ce1_n high, and write controls asserted during an adsp_n start. Byte-write bursts use single-byte masks, arbitrary masks, the global override and the no-enable case, and are then read back in full. That read-back shows whether enables are taken at the data edge or the address edge.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        CYC_DESEL,
        CYC_START_RD,
        CYC_START_WR,
        CYC_NEXT,
        CYC_HOLD
    } cyc_e;

    typedef enum logic [1:0] {
        ST_DESEL,
        ST_RD,
        ST_WR
    } st_e;

endpackage

// File: rtl/psram_cyc_decode.sv
module psram_cyc_decode
    import psram_pkg::*;
(
    input  logic ce1_n,
    input  logic ce2,
    input  logic ce3_n,
    input  logic adsp_n,
    input  logic adsc_n,
    input  logic adv_n,
    input  logic wr_req_i,
    output cyc_e cyc_o
);

    logic selected;
    logic adsp_live;

    always_comb begin
        selected  = !ce1_n && ce2 && !ce3_n;
        // the processor strobe only counts while the low-active enable is low
        adsp_live = !adsp_n && !ce1_n;
        if (adsp_live) begin
            cyc_o = selected ? CYC_START_RD : CYC_DESEL;
        end else if (!adsc_n) begin
            if (selected) begin
                cyc_o = wr_req_i ? CYC_START_WR : CYC_START_RD;
            end else begin
                cyc_o = CYC_DESEL;
            end
        end else if (!adv_n) begin
            cyc_o = CYC_NEXT;
        end else begin
            cyc_o = CYC_HOLD;
        end
    end

endmodule

// File: rtl/psram_burst_ctr.sv
module psram_burst_ctr #(
    parameter int ADDR_W  = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              linear_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] beat_addr_o
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] low_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            base_q <= ext_addr_i;
            cnt_q  <= '0;
        end else if (step_i) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (linear_i) begin
            low_bits = base_q[BURST_W-1:0] + cnt_q;
        end else begin
            low_bits = base_q[BURST_W-1:0] ^ cnt_q;
        end
    end

    generate
        if (ADDR_W > BURST_W) begin : g_with_upper
            assign beat_addr_o = {base_q[ADDR_W-1:BURST_W], low_bits};
        end else begin : g_low_only
            assign beat_addr_o = low_bits;
        end
    endgenerate

endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int NBYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [NBYTES-1:0] be_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int b = 0; b < NBYTES; b++) begin
            if (we_i && be_i[b]) begin
                mem[addr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
            end
        end
        rdata_o <= mem[addr_i];
    end

endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
    import psram_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int DEPTH     = 16,
    parameter int BURST_LEN = 4,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int NBYTES   = DATA_W / 8,
    localparam int BURST_W  = $clog2(BURST_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              linear_i,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NBYTES-1:0] bw_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);

    cyc_e              cyc;
    st_e               state_q;
    st_e               state_d;
    logic              wr_req;
    logic              ctr_load;
    logic              ctr_step;
    logic [ADDR_W-1:0] beat_addr;
    logic              arr_we;
    logic [NBYTES-1:0] arr_be;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] out_q;
    logic              rd_s1_q;
    logic              out_vld_q;

    assign wr_req   = !gw_n || !bwe_n;
    assign ctr_load = (cyc == CYC_START_RD) || (cyc == CYC_START_WR);
    assign ctr_step = (cyc == CYC_NEXT);

    psram_cyc_decode u_decode (
        .ce1_n    (ce1_n),
        .ce2      (ce2),
        .ce3_n    (ce3_n),
        .adsp_n   (adsp_n),
        .adsc_n   (adsc_n),
        .adv_n    (adv_n),
        .wr_req_i (wr_req),
        .cyc_o    (cyc)
    );

    psram_burst_ctr #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (ctr_load),
        .step_i      (ctr_step),
        .linear_i    (linear_i),
        .ext_addr_i  (addr_i),
        .beat_addr_o (beat_addr)
    );

    psram_array #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_array (
        .clk     (clk),
        .we_i    (arr_we),
        .be_i    (arr_be),
        .addr_i  (beat_addr),
        .wdata_i (wdata_i),
        .rdata_o (arr_rdata)
    );

    // next data-phase type for the address registered at this edge
    always_comb begin
        unique case (cyc)
            CYC_DESEL:    state_d = ST_DESEL;
            CYC_START_RD: state_d = ST_RD;
            CYC_START_WR: state_d = ST_WR;
            CYC_NEXT,
            CYC_HOLD: begin
                if (state_q == ST_DESEL) begin
                    state_d = ST_DESEL;
                end else begin
                    state_d = wr_req ? ST_WR : ST_RD;
                end
            end
            default:      state_d = ST_DESEL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: byte enables travel with the data of the current beat
    always_comb begin
        arr_we = (state_q == ST_WR);
        arr_be = '0;
        if (!gw_n) begin
            arr_be = '1;
        end else if (!bwe_n) begin
            arr_be = ~bw_n;
        end
        dq_oe_o = !oe_n && out_vld_q;
        dq_o    = out_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_s1_q   <= 1'b0;
            out_vld_q <= 1'b0;
            out_q     <= '0;
        end else begin
            rd_s1_q   <= (state_q == ST_RD);
            out_vld_q <= rd_s1_q;
            out_q     <= arr_rdata;
        end
    end

endmodule

// File: rtl/psram_burst_ctrl_chk.sv
module psram_burst_ctrl_chk #(
    parameter int ADDR_W  = 4,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              adv_n,
    input logic              linear_i,
    input logic              oe_n,
    input logic              dq_oe_o,
    input logic [ADDR_W-1:0] beat_addr
);

    logic sel;
    logic strobes_idle;

    assign sel          = !ce1_n && ce2 && !ce3_n;
    assign strobes_idle = (adsp_n || ce1_n) && adsc_n;

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe_o);

    assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && !adsc_n) |=> ##2 !dq_oe_o);

    assert_adsp_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !adsp_n) |=> ##2 (oe_n || dq_oe_o));

    assert_adsp_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !adsp_n) |=> (beat_addr == $past(addr_i)));

    assert_adsc_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && adsp_n && !adsc_n) |=> (beat_addr == $past(addr_i)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes_idle && adv_n) |=> $stable(beat_addr));

    assert_step_linear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes_idle && !adv_n && linear_i) |=>
        (beat_addr[BURST_W-1:0] == BURST_W'($past(beat_addr[BURST_W-1:0]) + 1'b1)));

    assert_step_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes_idle && !adv_n) |=> $stable(beat_addr[ADDR_W-1:BURST_W]));

endmodule

bind psram_burst_ctrl psram_burst_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .adsp_n    (adsp_n),
    .adsc_n    (adsc_n),
    .adv_n     (adv_n),
    .linear_i  (linear_i),
    .oe_n      (oe_n),
    .dq_oe_o   (dq_oe_o),
    .beat_addr (beat_addr)
);

// File: tb/psram_burst_ctrl_tb_top.sv
`timescale 1ns/1ps
module psram_burst_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr_i;
    logic        ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, linear_i;
    logic        gw_n, bwe_n, oe_n;
    logic [7:0]  bw_n;
    logic [63:0] wdata_i;
    logic [63:0] dq_o;
    logic        dq_oe_o;

    int errors = 0;
    int checks = 0;
    logic [63:0] exp_mem [16];

    always #4 clk = ~clk;

    psram_burst_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .linear_i(linear_i), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .oe_n(oe_n), .wdata_i(wdata_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] baddr(input logic [3:0] s, input int n, input logic lin);
        logic [1:0] nn;
        nn = 2'(n);
        return {s[3:2], lin ? 2'(s[1:0] + nn) : (s[1:0] ^ nn)};
    endfunction

    function automatic logic [63:0] mkdata(input int s);
        logic [31:0] a, b;
        a = 32'(s) * 32'h9E3779B1;
        b = (32'(s) * 32'h85EBCA6B) ^ 32'h5A5A5A5A;
        return {a, b};
    endfunction

    task automatic set_idle();
        ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
        adsp_n = 1'b1; adsc_n = 1'b0; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
        addr_i = '0; wdata_i = '0;
    endtask

    task automatic select();
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    endtask

    // read burst: cycle 0 starts, cycles 1..n-1 continue/suspend per adv_pat, then idle
    task automatic rd_burst(input logic [3:0] st, input logic lin, input logic use_adsc,
                            input logic wr_begin, input logic [7:0] adv_pat, input int n,
                            input logic ce1_hi, input logic oe_hi, input string req);
        logic [3:0] seq [8];
        int cnt;
        cnt = 0;
        linear_i = lin;
        oe_n = oe_hi;
        for (int c = 0; c < n + 2; c++) begin
            set_idle();
            if (c == 0) begin
                select();
                addr_i = st;
                if (use_adsc) begin adsp_n = 1'b1; adsc_n = 1'b0; end
                else begin adsp_n = 1'b0; adsc_n = 1'b1; end
                if (wr_begin) begin gw_n = 1'b0; bwe_n = 1'b0; bw_n = '0; wdata_i = '1; end
                seq[0] = st;
            end else if (c < n) begin
                adsc_n = 1'b1;
                adv_n = !adv_pat[c];
                if (adv_pat[c]) cnt++;
                seq[c] = baddr(st, cnt, lin);
                if (ce1_hi) begin ce1_n = 1'b1; adsp_n = 1'b0; end
                else begin select(); adsp_n = 1'b1; end
            end
            @(negedge clk);
            if (c >= 2) begin
                check({req, " oe"}, 64'(dq_oe_o), 64'(!oe_hi));
                if (!oe_hi) check({req, " data"}, dq_o, exp_mem[seq[c-2]]);
            end
        end
        oe_n = 1'b0;
    endtask

    // write burst: ctl = {gw_n, bwe_n, bw_n} for the data phase of each beat
    task automatic wr_burst(input logic [3:0] st, input logic lin,
                            input logic [3:0][9:0] ctl, input logic [3:0][63:0] dat);
        logic [3:0] typ;
        logic [7:0] be;
        typ = 4'b0001;
        linear_i = lin;
        for (int c = 0; c < 5; c++) begin
            set_idle();
            if (c == 0) begin
                select(); adsp_n = 1'b1; adsc_n = 1'b0; addr_i = st; gw_n = 1'b0;
            end else begin
                {gw_n, bwe_n, bw_n} = ctl[c-1];
                wdata_i = dat[c-1];
                if (c < 4) begin
                    select(); adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b0;
                    typ[c] = !ctl[c-1][9] || !ctl[c-1][8];
                end
            end
            @(negedge clk);
        end
        for (int j = 0; j < 4; j++) begin
            if (typ[j]) begin
                if (!ctl[j][9]) be = 8'hFF;
                else if (!ctl[j][8]) be = ~ctl[j][7:0];
                else be = 8'h00;
                for (int b = 0; b < 8; b++)
                    if (be[b]) exp_mem[baddr(st, j, lin)][b*8 +: 8] = dat[j][b*8 +: 8];
            end
        end
        set_idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0][9:0]  ctl;
        logic [3:0][63:0] dat;
        set_idle();
        oe_n = 1'b0;
        linear_i = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state, idle suspend-type inputs keep it quiet
        check("R11 reset oe", 64'(dq_oe_o), 64'd0);
        rst_n = 1'b1;
        adsc_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 R6 idle after reset", 64'(dq_oe_o), 64'd0);
        end

        // fill with global writes (R9, R4 write start)
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 4; j++) begin
                ctl[j] = {1'b0, 1'b1, 8'hFF};
                dat[j] = mkdata(k * 4 + j + 1);
            end
            wr_burst(4'(k * 4), 1'b1, ctl, dat);
        end

        // all starts, both orders (R3, R4, R5, R7)
        for (int lin = 0; lin < 2; lin++) begin
            for (int s = 0; s < 16; s++) begin
                rd_burst(4'(s), lin[0], s[1], s[0] & !s[1], 8'hFE, 4, 1'b0, 1'b0,
                         lin ? "R5 R7 R3 R4 linear" : "R5 R7 R3 R4 interleaved");
            end
        end

        // suspend in mid burst, continue with ce1 high and adsp low (R6, R2, R5)
        rd_burst(4'd6, 1'b1, 1'b0, 1'b0, 8'b0011_1010, 6, 1'b0, 1'b0, "R6 suspend");
        rd_burst(4'd9, 1'b0, 1'b0, 1'b0, 8'b0000_1110, 4, 1'b1, 1'b0, "R2 R5 ce1 high continue");

        // R8: oe high never drives
        rd_burst(4'd3, 1'b1, 1'b1, 1'b0, 8'hFE, 4, 1'b0, 1'b1, "R8 oe high");

        // byte-granular writes (R9, R10)
        for (int k = 0; k < 8; k++) begin
            ctl[0] = {1'b1, 1'b0, 8'(~(8'h01 << k))};
            ctl[1] = {1'b1, 1'b0, 8'(k * 37 + 5)};
            ctl[2] = {1'b0, k[0], 8'hFF};
            ctl[3] = {1'b1, 1'b1, 8'h00};
            for (int j = 0; j < 4; j++) dat[j] = mkdata(k * 4 + j + 100);
            wr_burst(4'((k * 5) % 16), k[1], ctl, dat);
        end
        for (int s = 0; s < 16; s += 4)
            rd_burst(4'(s), 1'b1, 1'b0, 1'b0, 8'hFE, 4, 1'b0, 1'b0, "R9 R10 byte readback");

        // decode sweep over enables and strobes (R1, R2, R3, R4)
        for (int ce = 0; ce < 8; ce++) begin
            for (int sb = 0; sb < 2; sb++) begin
                logic sel;
                logic [3:0] a;
                set_idle();
                ce1_n = ce[0]; ce2 = ce[1]; ce3_n = ce[2];
                a = 4'(ce * 2 + sb);
                addr_i = a;
                adsp_n = sb[0]; adsc_n = !sb[0];
                sel = !ce[0] && ce[1] && !ce[2];
                @(negedge clk);
                set_idle();
                @(negedge clk);
                @(negedge clk);
                check("R1 R2 decode oe", 64'(dq_oe_o), 64'(sel));
                if (sel) check("R1 R3 R4 decode data", dq_o, exp_mem[a]);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule